// File: doc/BRIEF.md
# HDLC Serial Frame Transmitter with Byte Queue

This block takes packet bytes from a host through a byte write port, holds them in an internal queue and sends them out as a serial HDLC bit stream, one bit for each pulse of a bit enable. Each packet is wrapped in an opening and a closing flag (7Eh). The data and the frame check sequence are protected by zero-bit insertion, and a CRC-16 check value is appended after the last data byte. The host marks the last byte of a packet with an end-of-packet bit written alongside it.

A rising edge on the control reset input empties the queue and sends exactly one abort byte (FEh). After that the line carries a fill pattern, either flags (7Eh) or all ones (FFh), until at least two new bytes are queued. The whole output stream can be inverted. A low-watermark flag compares the queue level against a threshold picked by a 3-bit code. A sticky overflow flag records writes that were dropped because the queue was full.

The transmit state machine has seven states. ST_FILL sends the fill byte. ST_OPEN sends the opening flag. ST_DATA sends a packet byte. ST_FCS_LO and ST_FCS_HI send the two check bytes. ST_CLOSE sends the closing flag. ST_ABORT sends FEh. Every decision is taken on the last bit of a byte:
- FILL, CLOSE and ABORT go to OPEN when at least two bytes are queued, and to FILL otherwise.
- OPEN always goes to DATA.
- DATA goes to FCS_LO after a byte marked end-of-packet. It goes to ABORT when the queue is empty and no end mark has been seen. Otherwise it stays in DATA with the next byte.
- FCS_LO goes to FCS_HI, and FCS_HI goes to CLOSE.
- A control reset edge forces ABORT at any time, overriding all of the above.

Top module: `hdlc_tx_ctrl`

## Requirements
- R1: A flush happens only on a 0-to-1 transition of `ctl_reset`. While `ctl_reset` stays high, writes are accepted and queued packets are sent; a second flush needs the input to go low and then high again.
- R2: A flush discards every queued byte and clears `ovf`. Bytes written before the flush are never sent.
- R3: Starting with the first bit-enable pulse after a flush, the line carries one abort byte FEh. Bits are sent least significant bit first, so the abort appears as a 0 followed by seven 1s.
- R4: Between frames the line repeats 7Eh when `ctl_fill_ones` is 0 and FFh when it is 1, sent LSB first with no bit insertion.
- R5: A frame starts only at a byte boundary where the queue holds at least two bytes. With a single byte queued, the fill pattern continues.
- R6: A frame is sent as: the opening flag 7Eh, then the data bytes LSB first in write order up to and including the byte written with `wr_eop`=1, then the check value, then the closing flag 7Eh.
- R7: After five consecutive 1s in data or check-value bits, a 0 is inserted. No 0 is inserted inside flags, abort or fill bytes, but a 0 that is already due at the end of the check value is still sent before the closing flag.
- R8: The check value is the reflected CRC-16 (polynomial 8408h, preset FFFFh) over the data bits. It is sent complemented, with the low byte first, each byte LSB first.
- R9: When `ctl_invert` is 1, `tx_bit` is the complement of every bit the line would carry otherwise, including flags, fill and the check value.
- R10: `low_wm` is 1 exactly when the queue holds fewer than 16 + 32 × `ctl_wm_sel` bytes.
- R11: The queue holds 256 bytes. A write while the queue is full is dropped and sets `ovf`, which stays at 1 until the next flush or `rst_n`.
- R12: If a packet's bytes run out before a byte marked end-of-packet has been sent, the abort byte FEh follows the last byte sent, and then the fill pattern.
- R13: `tx_bit` changes only on a clock edge where `bit_en` is 1, one line bit per such edge. After `rst_n` it reads 1 (with `ctl_invert`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write one byte into the queue |
| wr_byte | input | 8 | Byte to queue |
| wr_eop | input | 1 | Marks the written byte as the last of its packet |
| ctl_reset | input | 1 | Control reset; its rising edge flushes the queue and sends an abort |
| ctl_invert | input | 1 | Invert the whole output stream |
| ctl_fill_ones | input | 1 | Fill pattern select: 0 = 7Eh, 1 = FFh |
| ctl_wm_sel | input | 3 | Low-watermark threshold code |
| bit_en | input | 1 | Send one bit on this clock edge |
| tx_bit | output | 1 | Serial line bit |
| low_wm | output | 1 | Queue level below the selected threshold |
| ovf | output | 1 | Sticky flag for a dropped write |

## Verification
A line bit is produced on the same clock edge that samples `bit_en` high. The bench records each such edge and compares `tx_bit` at the following falling edge against the next entry of an expected-bit queue. That queue is filled by driver tasks that build abort, fill and frame bytes, zero insertion and the CRC from the requirements alone. `low_wm` and `ovf` are due one edge after the write or flush that changes the queue, and are checked at the falling edge after that write or flush. `bit_en` is held low while bytes are queued, so every expected stream starts from a known byte boundary.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

    typedef enum logic [2:0] {
        ST_FILL,
        ST_OPEN,
        ST_DATA,
        ST_FCS_LO,
        ST_FCS_HI,
        ST_CLOSE,
        ST_ABORT
    } tx_state_t;

    localparam logic [7:0] FLAG_BYTE  = 8'h7E;
    localparam logic [7:0] ABORT_BYTE = 8'hFE;
    localparam logic [7:0] IDLE_BYTE  = 8'hFF;
    localparam logic [15:0] CRC_POLY  = 16'h8408;
    localparam logic [15:0] CRC_INIT  = 16'hFFFF;

    // Reflected CRC-16 advanced over one byte, least significant bit first.
    function automatic logic [15:0] crc_step(input logic [15:0] crc_in,
                                             input logic [7:0]  data);
        logic [15:0] c;
        c = crc_in;
        for (int i = 0; i < 8; i++) begin
            if (c[0] ^ data[i]) c = (c >> 1) ^ CRC_POLY;
            else                c = c >> 1;
        end
        return c;
    endfunction

endpackage

// File: rtl/hdlc_tx_fifo.sv
module hdlc_tx_fifo #(
    parameter int DEPTH = 256,
    parameter int W     = 9,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_data,
    input  logic          pop,
    output logic [W-1:0]  rd_data,
    output logic [CW-1:0] count,
    output logic          ovf
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          full, wr_ok;

    assign full    = (count == CW'(DEPTH));
    assign wr_ok   = wr_en && !full && !flush;
    assign rd_data = mem[rp];

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wp] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
            ovf   <= 1'b0;
        end else if (flush) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
            ovf   <= 1'b0;
        end else begin
            if (wr_ok) wp <= wp + 1'b1;
            if (pop)   rp <= rp + 1'b1;
            count <= count + CW'(wr_ok) - CW'(pop);
            if (wr_en && full) ovf <= 1'b1;
        end
    end

endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer
    import hdlc_tx_pkg::*;
#(
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          bit_en,
    input  logic          fill_ones,
    input  logic [CW-1:0] fifo_cnt,
    input  logic [7:0]    head_byte,
    input  logic          head_eop,
    output logic          pop,
    output logic          raw_bit
);

    tx_state_t   state, n_state;
    logic [7:0]  shreg, n_shreg;
    logic [2:0]  bcnt, n_bcnt;
    logic [2:0]  ones, n_ones;
    logic        stuff_pend, n_stuff_pend;
    logic        cur_eop, n_cur_eop;
    logic [15:0] crc, n_crc;
    logic        n_raw;
    logic        in_stuffed;
    logic [7:0]  fill_byte;

    assign in_stuffed = (state == ST_DATA) || (state == ST_FCS_LO) || (state == ST_FCS_HI);
    assign fill_byte  = fill_ones ? IDLE_BYTE : FLAG_BYTE;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_FILL;
            shreg      <= FLAG_BYTE;
            bcnt       <= '0;
            ones       <= '0;
            stuff_pend <= 1'b0;
            cur_eop    <= 1'b0;
            crc        <= CRC_INIT;
            raw_bit    <= 1'b1;
        end else begin
            state      <= n_state;
            shreg      <= n_shreg;
            bcnt       <= n_bcnt;
            ones       <= n_ones;
            stuff_pend <= n_stuff_pend;
            cur_eop    <= n_cur_eop;
            crc        <= n_crc;
            raw_bit    <= n_raw;
        end
    end

    // Next state and outputs
    always_comb begin
        n_state      = state;
        n_shreg      = shreg;
        n_bcnt       = bcnt;
        n_ones       = ones;
        n_stuff_pend = stuff_pend;
        n_cur_eop    = cur_eop;
        n_crc        = crc;
        n_raw        = raw_bit;
        pop          = 1'b0;
        if (flush) begin
            n_state      = ST_ABORT;
            n_shreg      = ABORT_BYTE;
            n_bcnt       = '0;
            n_ones       = '0;
            n_stuff_pend = 1'b0;
        end else if (bit_en) begin
            if (stuff_pend) begin
                n_raw        = 1'b0;
                n_stuff_pend = 1'b0;
                n_ones       = '0;
            end else begin
                n_raw   = shreg[0];
                n_shreg = shreg >> 1;
                n_bcnt  = bcnt + 1'b1;
                if (in_stuffed) begin
                    if (shreg[0]) begin
                        n_ones = ones + 1'b1;
                        if (ones == 3'd4) n_stuff_pend = 1'b1;
                    end else begin
                        n_ones = '0;
                    end
                end
                if (bcnt == 3'd7) begin
                    unique case (state)
                        ST_FILL, ST_CLOSE, ST_ABORT: begin
                            if (fifo_cnt >= CW'(2)) begin
                                n_state = ST_OPEN;
                                n_shreg = FLAG_BYTE;
                                n_crc   = CRC_INIT;
                                n_ones  = '0;
                            end else begin
                                n_state = ST_FILL;
                                n_shreg = fill_byte;
                            end
                        end
                        ST_OPEN: begin
                            n_state   = ST_DATA;
                            pop       = 1'b1;
                            n_shreg   = head_byte;
                            n_cur_eop = head_eop;
                            n_crc     = crc_step(crc, head_byte);
                        end
                        ST_DATA: begin
                            if (cur_eop) begin
                                n_state = ST_FCS_LO;
                                n_shreg = ~crc[7:0];
                            end else if (fifo_cnt == '0) begin
                                n_state      = ST_ABORT;
                                n_shreg      = ABORT_BYTE;
                                n_ones       = '0;
                                n_stuff_pend = 1'b0;
                            end else begin
                                pop       = 1'b1;
                                n_shreg   = head_byte;
                                n_cur_eop = head_eop;
                                n_crc     = crc_step(crc, head_byte);
                            end
                        end
                        ST_FCS_LO: begin
                            n_state = ST_FCS_HI;
                            n_shreg = ~crc[15:8];
                        end
                        ST_FCS_HI: begin
                            n_state = ST_CLOSE;
                            n_shreg = FLAG_BYTE;
                            n_ones  = '0;
                        end
                        default: n_state = ST_FILL;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/hdlc_tx_ctrl.sv
module hdlc_tx_ctrl #(
    parameter int DEPTH   = 256,
    parameter int WM_BASE = 16,
    parameter int WM_STEP = 32,
    localparam int CW     = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_byte,
    input  logic       wr_eop,
    input  logic       ctl_reset,
    input  logic       ctl_invert,
    input  logic       ctl_fill_ones,
    input  logic [2:0] ctl_wm_sel,
    input  logic       bit_en,
    output logic       tx_bit,
    output logic       low_wm,
    output logic       ovf
);

    logic          ctl_q;
    logic          flush;
    logic          pop;
    logic [8:0]    head;
    logic [CW-1:0] fifo_cnt;
    logic          raw_bit;
    logic [15:0]   wm_thr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= 1'b0;
        else        ctl_q <= ctl_reset;
    end

    assign flush  = ctl_reset && !ctl_q;
    assign wm_thr = 16'(WM_BASE) + 16'(WM_STEP) * 16'(ctl_wm_sel);
    assign low_wm = 16'(fifo_cnt) < wm_thr;
    assign tx_bit = raw_bit ^ ctl_invert;

    hdlc_tx_fifo #(.DEPTH(DEPTH), .W(9)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .wr_en   (wr_en),
        .wr_data ({wr_eop, wr_byte}),
        .pop     (pop),
        .rd_data (head),
        .count   (fifo_cnt),
        .ovf     (ovf)
    );

    hdlc_tx_framer #(.CW(CW)) u_frm (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .bit_en    (bit_en),
        .fill_ones (ctl_fill_ones),
        .fifo_cnt  (fifo_cnt),
        .head_byte (head[7:0]),
        .head_eop  (head[8]),
        .pop       (pop),
        .raw_bit   (raw_bit)
    );

endmodule

// File: rtl/hdlc_tx_checker.sv
module hdlc_tx_checker #(
    parameter int DEPTH = 256,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ctl_reset,
    input logic          ctl_q,
    input logic          flush,
    input logic          wr_en,
    input logic          pop,
    input logic [CW-1:0] fifo_cnt,
    input logic          ovf,
    input logic          low_wm
);

    assert_level_no_flush_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q && ctl_reset && wr_en && fifo_cnt == '0) |=> (fifo_cnt == CW'(1)));

    assert_flush_empties_R2: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (fifo_cnt == '0 && !ovf));

    assert_empty_is_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_cnt == '0) |-> low_wm);

    assert_ovf_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !flush) |=> ovf);

    assert_no_overfill_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= CW'(DEPTH));

    assert_no_pop_empty_R12: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (fifo_cnt != '0));

endmodule

bind hdlc_tx_ctrl hdlc_tx_checker #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_reset (ctl_reset),
    .ctl_q     (ctl_q),
    .flush     (flush),
    .wr_en     (wr_en),
    .pop       (pop),
    .fifo_cnt  (fifo_cnt),
    .ovf       (ovf),
    .low_wm    (low_wm)
);

// File: tb/hdlc_tx_ctrl_tb_top.sv
`timescale 1ns/1ps
module hdlc_tx_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_byte = '0;
    logic       wr_eop = 1'b0;
    logic       ctl_reset = 1'b0;
    logic       ctl_invert = 1'b0;
    logic       ctl_fill_ones = 1'b0;
    logic [2:0] ctl_wm_sel = '0;
    logic       bit_en = 1'b0;
    logic       tx_bit, low_wm, ovf;

    int checks = 0;
    int errors = 0;
    bit exp_q[$];
    bit fired = 1'b0;
    int ones = 0;
    bit pend = 1'b0;
    bit [15:0] crc_m;
    string tag = "R3";
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    hdlc_tx_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_byte(wr_byte), .wr_eop(wr_eop),
        .ctl_reset(ctl_reset), .ctl_invert(ctl_invert), .ctl_fill_ones(ctl_fill_ones),
        .ctl_wm_sel(ctl_wm_sel), .bit_en(bit_en), .tx_bit(tx_bit), .low_wm(low_wm), .ovf(ovf)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor: one line bit due per clock edge that saw bit_en high (R13)
    always @(posedge clk) fired <= bit_en;
    always @(negedge clk) begin
        if (fired) begin
            if (exp_q.size() == 0) check({tag, " extra bit"}, 1, 0);
            else begin
                bit e;
                e = exp_q.pop_front();
                check(tag, int'(tx_bit), int'(e));
            end
        end
    end

    // Driver side: build expected bits
    task automatic push_bit(bit b, bit st);
        if (pend) begin
            exp_q.push_back(1'b0 ^ ctl_invert);
            pend = 1'b0;
            ones = 0;
        end
        exp_q.push_back(b ^ ctl_invert);
        if (st && b) begin
            ones++;
            if (ones == 5) pend = 1'b1;
        end else ones = 0;
    endtask

    task automatic push_byte(bit [7:0] b, bit st);
        for (int i = 0; i < 8; i++) push_bit(b[i], st);
    endtask

    task automatic crc_byte(bit [7:0] b);
        for (int i = 0; i < 8; i++) begin
            bit fb;
            fb = crc_m[0] ^ b[i];
            crc_m = crc_m >> 1;
            if (fb) crc_m = crc_m ^ 16'h8408;
        end
    endtask

    task automatic push_frame(bit [7:0] d[]);
        bit [15:0] fcs;
        push_byte(8'h7E, 1'b0);
        ones = 0;
        crc_m = 16'hFFFF;
        foreach (d[i]) begin
            crc_byte(d[i]);
            push_byte(d[i], 1'b1);
        end
        fcs = ~crc_m;
        push_byte(fcs[7:0], 1'b1);
        push_byte(fcs[15:8], 1'b1);
        push_byte(8'h7E, 1'b0);
    endtask

    task automatic write_byte(bit [7:0] b, bit eop);
        @(negedge clk);
        wr_en = 1'b1; wr_byte = b; wr_eop = eop;
        @(negedge clk);
        wr_en = 1'b0; wr_eop = 1'b0;
    endtask

    task automatic pulse_reset(bit keep_high);
        @(negedge clk);
        ctl_reset = 1'b1;
        @(negedge clk);
        if (!keep_high) ctl_reset = 1'b0;
        ones = 0;
        pend = 1'b0;
    endtask

    task automatic run_bits();
        int n;
        n = exp_q.size();
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bit_en = 1'b1;
        end
        @(negedge clk);
        bit_en = 1'b0;
        @(negedge clk);
        check({tag, " leftover"}, exp_q.size(), 0);
    endtask

    initial begin
        #400000;
        if (!done) begin
            check("watchdog", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R13 reset tx_bit", int'(tx_bit), 1);
        check("R10 reset low_wm", int'(low_wm), 1);
        check("R11 reset ovf", int'(ovf), 0);

        // R3/R4: abort then flag fill
        tag = "R3_R4 flag fill";
        ctl_fill_ones = 1'b0;
        pulse_reset(1'b0);
        push_byte(8'hFE, 1'b0);
        push_byte(8'h7E, 1'b0);
        push_byte(8'h7E, 1'b0);
        run_bits();

        // R4: ones fill
        tag = "R4 ones fill";
        ctl_fill_ones = 1'b1;
        pulse_reset(1'b0);
        push_byte(8'hFE, 1'b0);
        push_byte(8'hFF, 1'b0);
        push_byte(8'hFF, 1'b0);
        run_bits();

        // R1/R5/R6/R7/R8: frame sent while ctl_reset stays high
        tag = "R1_R6_R7_R8 frame";
        ctl_fill_ones = 1'b0;
        pulse_reset(1'b1);
        write_byte(8'hFF, 1'b0);
        write_byte(8'h7E, 1'b0);
        write_byte(8'h3C, 1'b1);
        push_byte(8'hFE, 1'b0);
        push_frame('{8'hFF, 8'h7E, 8'h3C});
        push_byte(8'h7E, 1'b0);
        run_bits();
        ctl_reset = 1'b0;

        // R9: inverted stream with ones fill
        tag = "R9 invert";
        ctl_invert = 1'b1;
        ctl_fill_ones = 1'b1;
        pulse_reset(1'b0);
        write_byte(8'hF8, 1'b0);
        write_byte(8'h1F, 1'b1);
        push_byte(8'hFE, 1'b0);
        push_frame('{8'hF8, 8'h1F});
        push_byte(8'hFF, 1'b0);
        run_bits();
        ctl_invert = 1'b0;

        // R5: a single queued byte does not start a frame
        tag = "R5 single byte";
        ctl_fill_ones = 1'b0;
        pulse_reset(1'b0);
        write_byte(8'hA5, 1'b1);
        push_byte(8'hFE, 1'b0);
        push_byte(8'h7E, 1'b0);
        push_byte(8'h7E, 1'b0);
        push_byte(8'h7E, 1'b0);
        run_bits();

        // R12: underrun abort
        tag = "R12 underrun";
        pulse_reset(1'b0);
        write_byte(8'h00, 1'b0);
        write_byte(8'h81, 1'b0);
        push_byte(8'hFE, 1'b0);
        push_byte(8'h7E, 1'b0);
        push_byte(8'h00, 1'b1);
        push_byte(8'h81, 1'b1);
        ones = 0;
        pend = 1'b0;
        push_byte(8'hFE, 1'b0);
        push_byte(8'h7E, 1'b0);
        run_bits();

        // R10: watermark thresholds
        pulse_reset(1'b0);
        ctl_wm_sel = 3'd0;
        for (int i = 0; i < 15; i++) write_byte(8'(i), 1'b0);
        check("R10 15 below 16", int'(low_wm), 1);
        write_byte(8'h10, 1'b0);
        check("R10 16 at 16", int'(low_wm), 0);
        ctl_wm_sel = 3'd1;
        #1;
        check("R10 16 below 48", int'(low_wm), 1);
        for (int i = 0; i < 32; i++) write_byte(8'(i), 1'b0);
        check("R10 48 at 48", int'(low_wm), 0);
        ctl_wm_sel = 3'd7;
        #1;
        check("R10 48 below 240", int'(low_wm), 1);

        // R11: overflow
        for (int i = 0; i < 208; i++) write_byte(8'(i), 1'b0);
        check("R11 full no ovf", int'(ovf), 0);
        check("R10 256 above 240", int'(low_wm), 0);
        write_byte(8'hEE, 1'b0);
        check("R11 ovf set", int'(ovf), 1);
        repeat (4) @(negedge clk);
        check("R11 ovf sticky", int'(ovf), 1);

        // R2: flush discards queue and clears ovf
        tag = "R2 flushed";
        pulse_reset(1'b0);
        check("R2 ovf cleared", int'(ovf), 0);
        check("R2 queue empty", int'(low_wm), 1);
        push_byte(8'hFE, 1'b0);
        push_byte(8'h7E, 1'b0);
        push_byte(8'h7E, 1'b0);
        run_bits();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule